// File: doc/BRIEF.md
# Pulse-Synchronized Channel Sequencer

This block drives the two-bit channel select of a receive amplifier in step with a free-running laser pulse generator. The select line must be settled before the laser fires, so it may only change at one programmable point inside each pulse period. That point is the cycle on which the generator's period counter equals a 32-bit offset. In auto mode, each such point loads the next of four programmable slot values, cycling through the slots. In manual mode, the same point loads a fixed manual selection.

The block also shapes the pulse for the data path. A one-cycle reset marks the first cycle of each raw pulse. The pulse sent on to the laser driver is the raw pulse one clock later. Downstream capture logic can therefore be cleared exactly one cycle before the laser fires.

Top module: `chan_seq`

## Requirements
- R1: In auto mode (`auto_mode`=1), successive offset matches load the slots in the order 0, 1, 2, 3 and then wrap to slot 0, advancing the slot index by one per match.
- R2: `chan_sel` changes only on the clock edge that samples `period_cnt == offset` with `en`=1. The new value is visible from that edge on. Without a match the output holds its value indefinitely, including when the offset is never reached.
- R3: In manual mode (`auto_mode`=0), an offset match loads `manual_sel` into `chan_sel` and leaves the slot index unchanged. A later auto-mode match continues from the slot it would have used next.
- R4: An edge that samples `en`=0 clears both the slot index and `chan_sel` to 0. After re-enabling, the first auto match loads slot 0.
- R5: `slot_word` carries slot 0 in bits [1:0], slot 1 in [5:4], slot 2 in [9:8] and slot 3 in [13:12]. All other bits of `slot_word` have no effect.
- R6: `dp_rst` is high for exactly one cycle: the cycle in which `pulse_raw` is high and was low at the previous clock edge.
- R7: `pulse_out` equals `pulse_raw` delayed by one clock, so its rising edge comes one cycle after `dp_rst`.
- R8: While `rst_n` is low, `chan_sel`, the slot index and `pulse_out` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the pulse generator |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Sequencer enable; low clears index and output |
| auto_mode | input | 1 | 1 = step through slots, 0 = manual selection |
| offset | input | 32 | Period-counter value at which the select updates |
| slot_word | input | 16 | Packed four auto-sequence slots |
| manual_sel | input | 2 | Channel used in manual mode |
| period_cnt | input | 32 | Pulse generator's period counter |
| pulse_raw | input | 1 | Pulse level from the generator |
| chan_sel | output | 2 | Registered amplifier channel select |
| dp_rst | output | 1 | One-cycle data-path reset at the raw pulse rising edge |
| pulse_out | output | 1 | Raw pulse delayed by one clock |

## Verification
`chan_sel` and `pulse_out` come from registers. Their result is due one edge after the inputs that cause it, so the bench drives on a falling edge and compares on the next falling edge. `dp_rst` is combinational from `pulse_raw` and the delayed pulse, so it is compared in the same half-cycle that `pulse_raw` is driven, before the next rising edge. The bench's reference model applies the previous cycle's inputs before each comparison. This keeps every expected value one register stage behind its stimulus.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;

    typedef enum logic {
        MODE_MANUAL = 1'b0,
        MODE_AUTO   = 1'b1
    } step_mode_e;

endpackage

// File: rtl/seq_pulse_stage.sv
module seq_pulse_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_raw,
    output logic dp_rst,
    output logic pulse_out
);

    typedef struct packed {
        logic pulse;
    } pstate_t;

    pstate_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = pulse_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dp_rst    = pulse_raw & ~st_q.pulse;
    assign pulse_out = st_q.pulse;

    AST_DPRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dp_rst |=> !dp_rst);                                         // R6
    AST_PULSE_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        dp_rst |=> $rose(pulse_out));                                // R7

endmodule

// File: rtl/seq_slot_pick.sv
module seq_slot_pick #(
    parameter int SEL_W     = 2,
    parameter int NUM_SLOTS = 4,
    parameter int STRIDE    = 4,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int WORD_W   = NUM_SLOTS * STRIDE
) (
    input  logic [WORD_W-1:0] slot_word,
    input  logic [IDX_W-1:0]  idx,
    output logic [SEL_W-1:0]  slot_val
);

    logic [SEL_W-1:0] slots [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_unpack
        assign slots[g] = slot_word[g*STRIDE +: SEL_W];
    end

    always_comb begin
        slot_val = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (idx == IDX_W'(k)) slot_val = slots[k];
        end
    end

endmodule

// File: rtl/seq_step_ctrl.sv
module seq_step_ctrl
    import chan_seq_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int SEL_W     = 2,
    parameter int NUM_SLOTS = 4,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             auto_mode,
    input  logic [CNT_W-1:0] period_cnt,
    input  logic [CNT_W-1:0] offset,
    input  logic [SEL_W-1:0] slot_val,
    input  logic [SEL_W-1:0] manual_sel,
    output logic [IDX_W-1:0] idx,
    output logic [SEL_W-1:0] chan_sel
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [SEL_W-1:0] chan;
    } step_state_t;

    step_state_t st_d, st_q;
    logic        hit;
    step_mode_e  mode;

    assign hit  = (period_cnt == offset);
    assign mode = step_mode_e'(auto_mode);

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.idx  = '0;
            st_d.chan = '0;
        end else if (hit) begin
            if (mode == MODE_AUTO) begin
                st_d.chan = slot_val;
                st_d.idx  = (st_q.idx == LAST_IDX) ? '0 : st_q.idx + 1'b1;
            end else begin
                st_d.chan = manual_sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx      = st_q.idx;
    assign chan_sel = st_q.chan;

    AST_AUTO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hit && auto_mode) |=> chan_sel == $past(slot_val));   // R1
    AST_AUTO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hit && auto_mode && idx == LAST_IDX) |=> idx == '0);  // R1
    AST_HOLD_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !hit) |=> $stable(chan_sel) && $stable(idx));         // R2
    AST_MANUAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hit && !auto_mode) |=> chan_sel == $past(manual_sel)); // R3
    AST_MANUAL_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hit && !auto_mode) |=> $stable(idx));                 // R3
    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (chan_sel == '0) && (idx == '0));                    // R4
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |-> (chan_sel == '0) && (idx == '0));                 // R8

endmodule

// File: rtl/chan_seq.sv
module chan_seq #(
    parameter int CNT_W     = 32,
    parameter int SEL_W     = 2,
    parameter int NUM_SLOTS = 4,
    parameter int STRIDE    = 4,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int WORD_W   = NUM_SLOTS * STRIDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              auto_mode,
    input  logic [CNT_W-1:0]  offset,
    input  logic [WORD_W-1:0] slot_word,
    input  logic [SEL_W-1:0]  manual_sel,
    input  logic [CNT_W-1:0]  period_cnt,
    input  logic              pulse_raw,
    output logic [SEL_W-1:0]  chan_sel,
    output logic              dp_rst,
    output logic              pulse_out
);

    logic [IDX_W-1:0] cur_idx;
    logic [SEL_W-1:0] cur_slot;

    seq_slot_pick #(
        .SEL_W     (SEL_W),
        .NUM_SLOTS (NUM_SLOTS),
        .STRIDE    (STRIDE)
    ) u_pick (
        .slot_word (slot_word),
        .idx       (cur_idx),
        .slot_val  (cur_slot)
    );

    seq_step_ctrl #(
        .CNT_W     (CNT_W),
        .SEL_W     (SEL_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .auto_mode  (auto_mode),
        .period_cnt (period_cnt),
        .offset     (offset),
        .slot_val   (cur_slot),
        .manual_sel (manual_sel),
        .idx        (cur_idx),
        .chan_sel   (chan_sel)
    );

    seq_pulse_stage u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_raw (pulse_raw),
        .dp_rst    (dp_rst),
        .pulse_out (pulse_out)
    );

endmodule

// File: tb/sim_chan_seq.sv
module sim_chan_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        auto_mode = 1'b1;
    logic [31:0] offset = 32'd7;
    logic [15:0] slot_word = 16'hCDFE;   // slots 2,3,1,0 plus junk in unused bits (R5)
    logic [1:0]  manual_sel = 2'd0;
    logic [31:0] period_cnt = 32'd0;
    logic        pulse_raw = 1'b0;
    logic [1:0]  chan_sel;
    logic        dp_rst;
    logic        pulse_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    chan_seq u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .auto_mode(auto_mode),
        .offset(offset), .slot_word(slot_word), .manual_sel(manual_sel),
        .period_cnt(period_cnt), .pulse_raw(pulse_raw),
        .chan_sel(chan_sel), .dp_rst(dp_rst), .pulse_out(pulse_out)
    );

    // row: {en, auto, hit, manual[1:0], expected chan[1:0]}
    localparam logic [6:0] TBL [0:13] = '{
        7'b1110010, 7'b1100010, 7'b1110011, 7'b1110001, 7'b1110000,
        7'b1110010, 7'b1011111, 7'b1000111, 7'b1010101, 7'b1110011,
        7'b0110000, 7'b0110000, 7'b1100000, 7'b1110010
    };
    localparam int TBL_REQ [0:13] = '{5, 2, 1, 1, 1, 1, 3, 2, 3, 3, 4, 4, 2, 4};
    localparam logic [1:0] SLOT_EXP [0:3] = '{2'd2, 2'd3, 2'd1, 2'd0};

    function automatic string req_name(int n);
        case (n)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] exp_chan;
        logic [1:0] exp_idx;
        logic       prev_hit;
        logic       prev_pulse;

        // reset state
        repeat (3) @(negedge clk);
        chk("R8", 32'(chan_sel), 32'd0);
        chk("R8", 32'(pulse_out), 32'd0);
        chk("R6", 32'(dp_rst), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int r = 0; r < 14; r++) begin
            en         = TBL[r][6];
            auto_mode  = TBL[r][5];
            period_cnt = TBL[r][4] ? offset : offset + 32'd5;
            manual_sel = TBL[r][3:2];
            @(negedge clk);
            chk(req_name(TBL_REQ[r]), 32'(chan_sel), 32'(TBL[r][1:0]));
        end

        // free-running counter, offset inside period; index now 1, chan 2
        exp_idx    = 2'd1;
        exp_chan   = 2'd2;
        prev_hit   = 1'b0;
        prev_pulse = 1'b0;
        en = 1'b1;
        auto_mode = 1'b1;
        for (int c = 0; c < 70; c++) begin
            if (c == 40) offset = 32'd50;   // never reached: output must hold (R2)
            period_cnt = 32'(c % 10);
            pulse_raw  = (c % 10) < 3;
            #1;
            chk("R6", 32'(dp_rst), 32'(pulse_raw & ~prev_pulse));
            @(negedge clk);
            if (prev_hit || (period_cnt == offset)) begin
                exp_chan = SLOT_EXP[exp_idx];
                exp_idx  = exp_idx + 2'd1;
            end
            prev_hit   = 1'b0;
            prev_pulse = pulse_raw;
            chk("R2", 32'(chan_sel), 32'(exp_chan));
            chk("R7", 32'(pulse_out), 32'(prev_pulse));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule